// File: doc/BRIEF.md
# EDID Segment and Offset Tracker

This block sits between a requester and the queue that feeds an AUX channel engine. Some display sinks handle the I2C middle-of-transaction flag badly during EDID reads and lose their read pointer between chunks. The block watches the request stream and keeps its own copy of two values: the EDID segment pointer and the EDID byte offset. Before a chunked EDID read that starts partway through a 128-byte block, it re-sends those values to the sink as short helper writes.

Requests enter on a valid/ready stream. Each request carries these fields:
- a native/I2C kind;
- a read flag;
- a middle-of-transaction flag;
- a target address;
- a byte count;
- the first data byte.

Requests leave on a second valid/ready stream. That stream adds two control flags: one that suppresses the address phase and one that suppresses the stop condition. Forwarded requests keep their fields and have both flags clear. Inserted helper writes have both flags set. The original read is accepted from the input only in the cycle it is handed downstream. This happens after every helper write has been taken.

Top module: `edid_ptr_tracker`

## Requirements
- R1: An accepted I2C write (kind I2C, read flag 0) to address 0x30 stores its first data byte as the segment value.
- R2: An accepted I2C write to address 0x50 stores its first data byte as the 8-bit offset value.
- R3: These requests leave the segment and the offset unchanged: native requests (whatever their address), I2C reads, and I2C writes to any address other than 0x30 and 0x50.
- R4: A request qualifies as a chunk read only when it is an I2C read with the middle-of-transaction flag set and a nonzero byte count. Any other request is forwarded alone and moves no stored value.
- R5: A qualifying read gets no helper writes when the stored offset is a multiple of 128.
- R6: Otherwise, when the segment is nonzero, the first helper is a write to address 0x30. It has byte count 1, its data byte is the segment, and its middle-of-transaction flag is clear.
- R7: The next helper is a write to the read's own target address. It has byte count 1, its data byte is the stored offset, and its middle-of-transaction flag is clear. Every helper has both the no-address flag and the no-stop flag set.
- R8: Each accepted qualifying read advances the offset by 16, modulo 256. When the new offset is a multiple of 128 (0x80, or 0x100 wrapping to 0x00), the segment becomes zero.
- R9: Output order is segment helper, then offset helper, then the original request. The input is accepted only in the cycle the original is accepted downstream. The original is forwarded with its fields unchanged and both control flags clear.
- R10: A synchronous reset sets both the segment and the offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Incoming request accepted this cycle when valid |
| in_native | input | 1 | 1 = native request, 0 = I2C request |
| in_read | input | 1 | 1 = read, 0 = write |
| in_mot | input | 1 | Middle-of-transaction flag |
| in_addr | input | ADDR_W (20) | Target address |
| in_len | input | LEN_W (8) | Byte count |
| in_data | input | 8 | First data byte |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Downstream can take a request |
| out_native | output | 1 | Kind of outgoing request |
| out_read | output | 1 | Read flag of outgoing request |
| out_mot | output | 1 | Middle-of-transaction flag of outgoing request |
| out_addr | output | ADDR_W (20) | Target address of outgoing request |
| out_len | output | LEN_W (8) | Byte count of outgoing request |
| out_data | output | 8 | First data byte of outgoing request |
| out_no_addr | output | 1 | Suppress address phase (set on helpers) |
| out_no_stop | output | 1 | Suppress stop condition (set on helpers) |

## Verification
The hardest case to reach is the segment-clearing boundary. The offset has to be walked up to 0x70 (or 0xF0) with a nonzero segment in place, and the state is visible only through the helper writes that later reads produce. The stimulus therefore plants a segment and an offset with ordinary I2C writes to 0x30 and 0x50. It then issues a sequence of chunk reads, so that each crossing shows up as a missing segment helper on the read after the next. Downstream backpressure runs in a steady pattern and in a pseudo-random pattern, so that the input stalls while helpers are still pending.

// File: rtl/edid_trk_pkg.sv
package edid_trk_pkg;
  typedef enum logic [1:0] {PH_START, PH_OFS, PH_ORIG} phase_t;
  typedef enum logic [1:0] {EM_NONE, EM_SEG, EM_OFS, EM_ORIG} emit_t;
endpackage

// File: rtl/edid_ptr_regs.sv
module edid_ptr_regs #(
  parameter int ADDR_W    = 20,
  parameter int LEN_W     = 8,
  parameter int DW        = 8,
  parameter int SEG_ADDR  = 'h30,
  parameter int EDID_ADDR = 'h50,
  parameter int CHUNK     = 16,
  parameter int BLOCK     = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DW-1:0]     req_data,
  output logic [DW-1:0]     seg_q,
  output logic [DW-1:0]     ofs_q,
  output logic              chunk_rd,
  output logic              need_help
);
  localparam int BLK_LG = $clog2(BLOCK);

  function automatic logic [DW-1:0] step_ofs(input logic [DW-1:0] o);
    return o + DW'(CHUNK);
  endfunction

  function automatic logic at_block_edge(input logic [DW-1:0] o);
    return o[BLK_LG-1:0] == '0;
  endfunction

  logic wr_seg, wr_ofs, advance, i2c_wr;
  logic [DW-1:0] ofs_next;

  assign chunk_rd  = !req_native && req_read && req_mot && (req_len != '0);
  assign need_help = chunk_rd && !at_block_edge(ofs_q);
  assign i2c_wr    = fire && !req_native && !req_read;
  assign wr_seg    = i2c_wr && (req_addr == ADDR_W'(SEG_ADDR));
  assign wr_ofs    = i2c_wr && (req_addr == ADDR_W'(EDID_ADDR));
  assign advance   = fire && chunk_rd;
  assign ofs_next  = step_ofs(ofs_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      ofs_q <= '0;
    end else begin
      if (wr_seg) seg_q <= req_data;
      if (wr_ofs) ofs_q <= req_data;
      if (advance) begin
        ofs_q <= ofs_next;
        if (at_block_edge(ofs_next)) seg_q <= '0;
      end
    end
  end

  // R8
  ofs_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> ofs_q == DW'($past(ofs_q) + CHUNK));

  // R8
  seg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && ofs_q[BLK_LG-1:0] == BLK_LG'(BLOCK - CHUNK)) |=> seg_q == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire) |=> ($stable(seg_q) && $stable(ofs_q)));

  // R10
  reset_chk: assert property (@(posedge clk)
    rst |=> (seg_q == '0 && ofs_q == '0));
endmodule

// File: rtl/edid_req_seq.sv
module edid_req_seq #(
  parameter int ADDR_W   = 20,
  parameter int LEN_W    = 8,
  parameter int DW       = 8,
  parameter int SEG_ADDR = 'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_native,
  input  logic              in_read,
  input  logic              in_mot,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DW-1:0]     in_data,
  input  logic              need_help,
  input  logic [DW-1:0]     seg_q,
  input  logic [DW-1:0]     ofs_q,
  output logic              orig_fire,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_native,
  output logic              out_read,
  output logic              out_mot,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic [DW-1:0]     out_data,
  output logic              out_no_addr,
  output logic              out_no_stop
);
  import edid_trk_pkg::*;

  phase_t phase;
  emit_t  emit;
  logic   out_fire, helper_out;

  always_comb begin
    emit = EM_NONE;
    unique case (phase)
      PH_START: if (in_valid) begin
        if (need_help) emit = (seg_q != '0) ? EM_SEG : EM_OFS;
        else           emit = EM_ORIG;
      end
      PH_OFS:  emit = EM_OFS;
      PH_ORIG: emit = EM_ORIG;
      default: emit = EM_NONE;
    endcase
  end

  assign helper_out = (emit == EM_SEG) || (emit == EM_OFS);
  assign out_valid  = emit != EM_NONE;
  assign out_fire   = out_valid && out_ready;
  assign in_ready   = (emit == EM_ORIG) && out_ready;
  assign orig_fire  = in_valid && in_ready;

  always_comb begin
    out_native  = in_native;
    out_read    = in_read;
    out_mot     = in_mot;
    out_addr    = in_addr;
    out_len     = in_len;
    out_data    = in_data;
    out_no_addr = 1'b0;
    out_no_stop = 1'b0;
    if (helper_out) begin
      out_native  = 1'b0;
      out_read    = 1'b0;
      out_mot     = 1'b0;
      out_len     = LEN_W'(1);
      out_no_addr = 1'b1;
      out_no_stop = 1'b1;
      if (emit == EM_SEG) begin
        out_addr = ADDR_W'(SEG_ADDR);
        out_data = seg_q;
      end else begin
        out_data = ofs_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_START;
    end else if (out_fire) begin
      unique case (emit)
        EM_SEG:  phase <= PH_OFS;
        EM_OFS:  phase <= PH_ORIG;
        default: phase <= PH_START;
      endcase
    end
  end

  // R9
  helper_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fire && helper_out) |=> (out_valid && !in_ready || out_valid));

  // R9
  no_early_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fire && helper_out) |-> !orig_fire);

  // R5
  no_help_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_START && in_valid && !need_help) |-> !out_no_addr);
endmodule

// File: rtl/edid_ptr_tracker.sv
module edid_ptr_tracker #(
  parameter int ADDR_W    = 20,
  parameter int LEN_W     = 8,
  parameter int SEG_ADDR  = 'h30,
  parameter int EDID_ADDR = 'h50,
  parameter int CHUNK     = 16,
  parameter int BLOCK     = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_native,
  input  logic              in_read,
  input  logic              in_mot,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_native,
  output logic              out_read,
  output logic              out_mot,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic [7:0]        out_data,
  output logic              out_no_addr,
  output logic              out_no_stop
);
  localparam int DW = 8;

  logic [DW-1:0] seg_q, ofs_q;
  logic          chunk_rd, need_help, orig_fire;

  edid_ptr_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW(DW), .SEG_ADDR(SEG_ADDR),
    .EDID_ADDR(EDID_ADDR), .CHUNK(CHUNK), .BLOCK(BLOCK)
  ) u_regs (
    .clk(clk), .rst(rst), .fire(orig_fire),
    .req_native(in_native), .req_read(in_read), .req_mot(in_mot),
    .req_addr(in_addr), .req_len(in_len), .req_data(in_data),
    .seg_q(seg_q), .ofs_q(ofs_q), .chunk_rd(chunk_rd), .need_help(need_help)
  );

  edid_req_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW(DW), .SEG_ADDR(SEG_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_native(in_native), .in_read(in_read), .in_mot(in_mot),
    .in_addr(in_addr), .in_len(in_len), .in_data(in_data),
    .need_help(need_help), .seg_q(seg_q), .ofs_q(ofs_q),
    .orig_fire(orig_fire),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_native(out_native), .out_read(out_read), .out_mot(out_mot),
    .out_addr(out_addr), .out_len(out_len), .out_data(out_data),
    .out_no_addr(out_no_addr), .out_no_stop(out_no_stop)
  );

  // R4
  qual_only_chk: assert property (@(posedge clk) disable iff (rst)
    (orig_fire && !chunk_rd) |=> $stable(ofs_q) || !$past(in_native) && !$past(in_read));
endmodule

// File: tb/edid_ptr_tracker_bench.sv
`timescale 1ns/1ps
module edid_ptr_tracker_bench;
  localparam int AW = 20;
  localparam int LW = 8;

  typedef struct packed {
    logic          native;
    logic          rd;
    logic          mot;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    logic [7:0]    data;
    logic          na;
    logic          ns;
  } item_t;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_native = 0, in_read = 0, in_mot = 0;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic [7:0] in_data = '0;
  logic out_ready = 1;
  logic in_ready, out_valid, out_native, out_read, out_mot, out_no_addr, out_no_stop;
  logic [AW-1:0] out_addr;
  logic [LW-1:0] out_len;
  logic [7:0] out_data;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  logic [7:0] m_seg = 0, m_ofs = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #2.5 clk = ~clk;

  edid_ptr_tracker u_edid_ptr_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_native(in_native), .in_read(in_read), .in_mot(in_mot),
    .in_addr(in_addr), .in_len(in_len), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_native(out_native), .out_read(out_read), .out_mot(out_mot),
    .out_addr(out_addr), .out_len(out_len), .out_data(out_data),
    .out_no_addr(out_no_addr), .out_no_stop(out_no_stop)
  );

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0: out_ready <= 1'b1;
      1: out_ready <= ~out_ready;
      default: out_ready <= lfsr[0] | lfsr[2];
    endcase
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      item_t got, ex;
      string t;
      got = '{out_native, out_read, out_mot, out_addr, out_len, out_data, out_no_addr, out_no_stop};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected output item %h, expected none", got);
      end else begin
        ex = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== ex) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, got, ex);
        end
      end
    end
  end

  task automatic push(item_t it, string t);
    exp_q.push_back(it);
    tag_q.push_back(t);
  endtask

  task automatic send(bit nat, bit rd, bit mot, int addr, int len, int data, string t);
    bit q;
    q = !nat && rd && mot && (len != 0);
    if (q && (m_ofs % 128) != 0) begin
      if (m_seg != 0)
        push('{1'b0, 1'b0, 1'b0, AW'('h30), LW'(1), m_seg, 1'b1, 1'b1}, {t, "/R6"});
      push('{1'b0, 1'b0, 1'b0, AW'(addr), LW'(1), m_ofs, 1'b1, 1'b1}, {t, "/R7"});
    end
    push('{nat, rd, mot, AW'(addr), LW'(len), 8'(data), 1'b0, 1'b0}, {t, "/R9"});
    if (q) begin
      m_ofs = m_ofs + 8'd16;
      if (m_ofs == 8'h80 || m_ofs == 8'h00) m_seg = 0;
    end
    if (!nat && !rd && addr == 'h30) m_seg = 8'(data);
    if (!nat && !rd && addr == 'h50) m_ofs = 8'(data);
    in_native = nat; in_read = rd; in_mot = mot;
    in_addr = AW'(addr); in_len = LW'(len); in_data = 8'(data);
    in_valid = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    m_seg = 0; m_ofs = 0;
  endtask

  task automatic chunk(string t);
    send(0, 1, 1, 'h50, 16, 0, t);
  endtask

  initial begin
    do_reset();
    // R10: reset state -> offset 0, no helpers; then offset 16 -> one helper
    chunk("R10"); chunk("R8");
    // R1, R2 snoop then helper pair with segment
    send(0, 0, 0, 'h30, 1, 2, "R1");
    send(0, 0, 0, 'h50, 1, 'h20, "R2");
    chunk("R6");
    // R3: native write to 0x50, i2c write to 0x51, i2c read of 0x30
    send(1, 0, 0, 'h50, 1, 'h99, "R3");
    send(0, 0, 0, 'h51, 1, 'h44, "R3");
    send(0, 1, 0, 'h30, 1, 'h77, "R3");
    chunk("R3");
    // R4: no mot, zero length, native read with mot
    send(0, 1, 0, 'h50, 16, 0, "R4");
    send(0, 1, 1, 'h50, 0, 0, "R4");
    send(1, 1, 1, 'h50, 16, 0, "R4");
    chunk("R4");
    rmode = 1;
    // R8: crossing 0x80 clears segment
    send(0, 0, 0, 'h30, 1, 1, "R1");
    send(0, 0, 0, 'h50, 1, 'h70, "R2");
    chunk("R8"); chunk("R5"); chunk("R8");
    // R7 target address other than 0x50
    send(0, 0, 0, 'h30, 1, 3, "R1");
    send(0, 1, 1, 'h52, 8, 0, "R7");
    rmode = 2;
    // R8: wrap 0xF0 -> 0x00 clears segment
    send(0, 0, 0, 'h50, 1, 'hF0, "R2");
    chunk("R8"); chunk("R5"); chunk("R8");
    // R5: offset 0x80 planted directly, nonzero segment
    send(0, 0, 0, 'h30, 1, 5, "R1");
    send(0, 0, 0, 'h50, 1, 'h80, "R5");
    chunk("R5"); chunk("R6");
    // R10: reset mid-stream clears stored values
    send(0, 0, 0, 'h50, 1, 'h33, "R2");
    do_reset();
    chunk("R10"); chunk("R10");
    repeat (10) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d items never emitted, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule